// File: doc/BRIEF.md
# Vertically Gated Scanout Base Address Register

This block holds the frame-base address for one scanout channel in two stages. Software writes a new surface address into a staging register, which raises a pending flag. The staged value moves into the live register that the pixel fetcher reads, but only inside a vertical update window near the end of vertical blanking. The move also needs the update lock to be released. With this rule a frame is always fetched from a single surface, and the fetcher never switches surfaces part way down the screen.

A line counter advances on a line strobe and wraps at the vertical total. When it wraps it gives a one-cycle frame-start pulse. The update window opens on the first blanking line. It closes at a computed start line, which sits a programmable number of lines ahead of the first visible line of the next frame. That close point can be moved one line earlier. Progressive and interlaced timing each have their own setting for this. A request staged while the window is still open lands in the same blanking period. A request staged after the window has closed lands in the next frame.

Top module: `scanout_base_latch`

## Requirements
- R1: After reset the live address is 0, the pending flag is 0, the line counter is 0 and the control readback equals 0x0004_0100.
- R2: Each cycle with `line_tick` high advances the line counter by one. From VTOTAL-1 it wraps to 0, and `frame_start` is then high for exactly the one cycle after the wrap.
- R3: `in_window` and status bit 4 are 1 exactly when VACTIVE <= line < start_line, where start_line = VTOTAL - lead - early.
- R4: The lead is the control field at bits 19:16 (reset 4). If lead + early exceeds VTOTAL - VACTIVE, the window is empty.
- R5: `early` is control bit 0 when `interlace_mode` is 0, and control bit 8 (reset 1) when `interlace_mode` is 1. The bit for the other mode has no effect.
- R6: A write on the staging port stores the address and sets the pending flag, which shows on `pending` and status bit 0.
- R7: The live address takes the staged value only in a cycle where the pending flag is 1, the lock is 0 and the line is in the window. The pending flag clears in that same update, unless a new write arrives in that cycle.
- R8: A request staged while the window is open lands in that frame. A request staged after the window has closed lands in the next frame's window.
- R9: While `upd_lock` is 1, no update takes place, even inside the window, and further writes only replace the staged value. After the lock is released, the latest staged value lands in the next window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_tick | input | 1 | One-cycle strobe per scan line |
| interlace_mode | input | 1 | 1 selects interlaced timing for the early-close bit |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 32 | Control write data (bit 0, bit 8, bits 19:16) |
| ctrl_rdata | output | 32 | Control register readback |
| status_rdata | output | 32 | Status: bit 0 pending, bit 4 in window |
| addr_we | input | 1 | Staging address write strobe |
| addr_wdata | input | ADDR_W (32) | New surface address |
| upd_lock | input | 1 | Update lock; 1 blocks the update |
| active_addr | output | ADDR_W (32) | Live frame-base address |
| pending | output | 1 | Staged address not yet applied |
| in_window | output | 1 | Current line is inside the update window |
| line_count | output | LINE_W (5) | Current vertical line |
| frame_start | output | 1 | One-cycle pulse after the counter wraps |

## Verification
A miscomputed close line shows at the ports as an update that lands one frame early or one frame late. It also shows as a wrong `in_window` value on the one boundary line, visible within the same line period. A pending flag that is stuck high or low shows on `pending` one cycle after the write or after the update. A live register that ignores the lock or the window changes value during active lines or while locked. The scoreboard records this against the frame number in which the change appears.

// File: rtl/sbl_pkg.sv
package sbl_pkg;
   localparam int CTRL_EARLY_PROG_BIT = 0;
   localparam int CTRL_EARLY_INTL_BIT = 8;
   localparam int CTRL_LEAD_LSB       = 16;
   localparam int CTRL_LEAD_W         = 4;
   localparam int STAT_PEND_BIT       = 0;
   localparam int STAT_WIN_BIT        = 4;

   localparam logic [CTRL_LEAD_W-1:0] LEAD_RESET = 4'd4;

   typedef struct packed {
      logic [CTRL_LEAD_W-1:0] lead;
      logic                   early_intl;
      logic                   early_prog;
   } ctrl_t;
endpackage

// File: rtl/sbl_line_counter.sv
module sbl_line_counter #(
   parameter int VTOTAL = 20,
   parameter int LINE_W = $clog2(VTOTAL)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_tick,
   output logic [LINE_W-1:0] line,
   output logic              frame_start
);
   logic last_line;

   generate
      if ((1 << LINE_W) == VTOTAL) begin : g_pow2
         assign last_line = &line;
      end else begin : g_cmp
         assign last_line = (line == LINE_W'(VTOTAL - 1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line        <= '0;
         frame_start <= 1'b0;
      end else begin
         frame_start <= 1'b0;
         if (line_tick) begin
            if (last_line) begin
               line        <= '0;
               frame_start <= 1'b1;
            end else begin
               line <= line + 1'b1;
            end
         end
      end
   end

   // R2: wrap lands on line 0 together with the frame pulse
   a_r2_wrap_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (line_tick && line == LINE_W'(VTOTAL - 1)) |=> (frame_start && line == '0));
   // R2: the pulse lasts one cycle
   a_r2_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> !frame_start);
endmodule

// File: rtl/sbl_window_decode.sv
module sbl_window_decode
   import sbl_pkg::*;
#(
   parameter int VTOTAL  = 20,
   parameter int VACTIVE = 12,
   parameter int LINE_W  = $clog2(VTOTAL)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LINE_W-1:0] line,
   input  ctrl_t             ctrl,
   input  logic              interlace_mode,
   output logic              in_window
);
   localparam int          CW     = LINE_W + 1;
   localparam int unsigned VBLANK = VTOTAL - VACTIVE;

   logic          early;
   logic [31:0]   back;
   logic [CW-1:0] start_line;
   logic [CW-1:0] line_x;

   assign early  = interlace_mode ? ctrl.early_intl : ctrl.early_prog;
   assign line_x = {1'b0, line};

   always_comb begin
      back = 32'(ctrl.lead) + 32'(early);
      if (back > VBLANK) start_line = CW'(VACTIVE);
      else               start_line = CW'(32'(VTOTAL) - back);
   end

   assign in_window = (line_x >= CW'(VACTIVE)) && (line_x < start_line);

   // R3: the window never reaches into active display
   a_r3_window_in_blank: assert property (@(posedge clk) disable iff (!rst_n)
      in_window |-> (line_x >= CW'(VACTIVE) && line_x < CW'(VTOTAL)));
endmodule

// File: rtl/sbl_base_latch.sv
module sbl_base_latch #(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic              lock,
   input  logic              in_window,
   output logic [ADDR_W-1:0] active_addr,
   output logic              pending
);
   logic [ADDR_W-1:0] staged_addr;
   logic              do_copy;

   assign do_copy = pending && !lock && in_window;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         staged_addr <= '0;
         active_addr <= '0;
         pending     <= 1'b0;
      end else begin
         if (do_copy) active_addr <= staged_addr;
         if (wr_en) begin
            staged_addr <= wr_addr;
            pending     <= 1'b1;
         end else if (do_copy) begin
            pending <= 1'b0;
         end
      end
   end

   // R6: a staging write always raises the flag
   a_r6_write_sets: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> pending);
   // R7: live address moves only under all three conditions
   a_r7_copy_gated: assert property (@(posedge clk) disable iff (!rst_n)
      (active_addr != $past(active_addr)) |-> $past(pending && !lock && in_window));
   // R7: flag drops after an update with no fresh write
   a_r7_flag_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (pending && !lock && in_window && !wr_en) |=> !pending);
   // R9: lock freezes the live address
   a_r9_lock_hold: assert property (@(posedge clk) disable iff (!rst_n)
      lock |=> $stable(active_addr));
endmodule

// File: rtl/scanout_base_latch.sv
module scanout_base_latch
   import sbl_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int VTOTAL  = 20,
   parameter int VACTIVE = 12,
   parameter int LINE_W  = $clog2(VTOTAL)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_tick,
   input  logic              interlace_mode,
   input  logic              ctrl_we,
   input  logic [31:0]       ctrl_wdata,
   output logic [31:0]       ctrl_rdata,
   output logic [31:0]       status_rdata,
   input  logic              addr_we,
   input  logic [ADDR_W-1:0] addr_wdata,
   input  logic              upd_lock,
   output logic [ADDR_W-1:0] active_addr,
   output logic              pending,
   output logic              in_window,
   output logic [LINE_W-1:0] line_count,
   output logic              frame_start
);
   generate
      if (VACTIVE < 1 || VACTIVE >= VTOTAL) begin : g_bad_vactive
         $error("VACTIVE must lie in 1..VTOTAL-1");
      end
      if (ADDR_W < 1) begin : g_bad_addr
         $error("ADDR_W must be positive");
      end
      if ((1 << LINE_W) < VTOTAL) begin : g_bad_linew
         $error("LINE_W too narrow for VTOTAL");
      end
   endgenerate

   ctrl_t ctrl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q.lead       <= LEAD_RESET;
         ctrl_q.early_intl <= 1'b1;
         ctrl_q.early_prog <= 1'b0;
      end else if (ctrl_we) begin
         ctrl_q.lead       <= ctrl_wdata[CTRL_LEAD_LSB +: CTRL_LEAD_W];
         ctrl_q.early_intl <= ctrl_wdata[CTRL_EARLY_INTL_BIT];
         ctrl_q.early_prog <= ctrl_wdata[CTRL_EARLY_PROG_BIT];
      end
   end

   always_comb begin
      ctrl_rdata = '0;
      ctrl_rdata[CTRL_LEAD_LSB +: CTRL_LEAD_W] = ctrl_q.lead;
      ctrl_rdata[CTRL_EARLY_INTL_BIT]          = ctrl_q.early_intl;
      ctrl_rdata[CTRL_EARLY_PROG_BIT]          = ctrl_q.early_prog;
      status_rdata = '0;
      status_rdata[STAT_PEND_BIT] = pending;
      status_rdata[STAT_WIN_BIT]  = in_window;
   end

   sbl_line_counter #(.VTOTAL(VTOTAL), .LINE_W(LINE_W)) u_lines (
      .clk         (clk),
      .rst_n       (rst_n),
      .line_tick   (line_tick),
      .line        (line_count),
      .frame_start (frame_start)
   );

   sbl_window_decode #(.VTOTAL(VTOTAL), .VACTIVE(VACTIVE), .LINE_W(LINE_W)) u_window (
      .clk            (clk),
      .rst_n          (rst_n),
      .line           (line_count),
      .ctrl           (ctrl_q),
      .interlace_mode (interlace_mode),
      .in_window      (in_window)
   );

   sbl_base_latch #(.ADDR_W(ADDR_W)) u_latch (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (addr_we),
      .wr_addr     (addr_wdata),
      .lock        (upd_lock),
      .in_window   (in_window),
      .active_addr (active_addr),
      .pending     (pending)
   );

   // R1: control readback holds its reset value until written
   a_r1_ctrl_reset: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(ctrl_we) |-> $stable(ctrl_rdata));
endmodule

// File: tb/scanout_base_latch_tb.sv
module scanout_base_latch_tb;
   localparam int CLK_P   = 10;
   localparam int ADDR_W  = 32;
   localparam int VTOTAL  = 20;
   localparam int VACTIVE = 12;
   localparam int LINE_W  = 5;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              line_tick = 1'b0;
   logic              interlace_mode = 1'b0;
   logic              ctrl_we = 1'b0;
   logic [31:0]       ctrl_wdata = '0;
   logic [31:0]       ctrl_rdata;
   logic [31:0]       status_rdata;
   logic              addr_we = 1'b0;
   logic [ADDR_W-1:0] addr_wdata = '0;
   logic              upd_lock = 1'b0;
   logic [ADDR_W-1:0] active_addr;
   logic              pending;
   logic              in_window;
   logic [LINE_W-1:0] line_count;
   logic              frame_start;

   int checks = 0;
   int failures = 0;
   int frame_id = 0;
   bit mon_on = 1'b0;
   logic [31:0] ctrl_shadow = 32'h0004_0100;

   typedef struct {
      logic [ADDR_W-1:0] addr;
      int                frame;
   } exp_t;
   exp_t exp_q[$];

   always #(CLK_P/2) clk = ~clk;

   scanout_base_latch #(.ADDR_W(ADDR_W), .VTOTAL(VTOTAL), .VACTIVE(VACTIVE), .LINE_W(LINE_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .line_tick(line_tick), .interlace_mode(interlace_mode),
      .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .ctrl_rdata(ctrl_rdata),
      .status_rdata(status_rdata), .addr_we(addr_we), .addr_wdata(addr_wdata),
      .upd_lock(upd_lock), .active_addr(active_addr), .pending(pending),
      .in_window(in_window), .line_count(line_count), .frame_start(frame_start)
   );

   task automatic check(string req, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int model_start();
      int back;
      back = int'(ctrl_shadow[19:16]) + int'(interlace_mode ? ctrl_shadow[8] : ctrl_shadow[0]);
      return (back > VTOTAL - VACTIVE) ? VACTIVE : VTOTAL - back;
   endfunction

   // line strobe every fourth cycle
   initial begin
      forever begin
         for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            line_tick = (i == 3) && rst_n;
         end
      end
   end

   task automatic wait_line(int n);
      do @(negedge clk); while (line_count == LINE_W'(n));
      do @(negedge clk); while (line_count != LINE_W'(n));
   endtask

   task automatic stage(logic [ADDR_W-1:0] a);
      addr_we = 1'b1;
      addr_wdata = a;
      @(negedge clk);
      addr_we = 1'b0;
   endtask

   task automatic request(logic [ADDR_W-1:0] a);
      exp_t e;
      e.addr  = a;
      e.frame = (int'(line_count) < model_start()) ? frame_id : frame_id + 1;
      exp_q.push_back(e);
      stage(a);
   endtask

   task automatic write_ctrl(logic [31:0] v);
      ctrl_we = 1'b1;
      ctrl_wdata = v;
      @(negedge clk);
      ctrl_we = 1'b0;
      ctrl_shadow = v;
   endtask

   // monitor: frame counting and scoreboard compare
   initial begin
      logic [ADDR_W-1:0] prev;
      prev = '0;
      forever begin
         @(negedge clk);
         if (mon_on) begin
            if (frame_start) frame_id++;
            if (active_addr !== prev) begin
               if (exp_q.size() == 0) begin
                  check("R7 unexpected update", 64'(active_addr), 64'(prev));
               end else begin
                  exp_t e;
                  e = exp_q.pop_front();
                  check("R8 address", 64'(active_addr), 64'(e.addr));
                  check("R8 frame", 64'(frame_id), 64'(e.frame));
                  check("R3 update inside window",
                        64'(int'(line_count) >= VACTIVE && int'(line_count) < model_start()), 64'(1));
               end
               prev = active_addr;
            end
         end
      end
   end

   initial begin
      #(CLK_P * 150000);
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset values
      check("R1 active", 64'(active_addr), 64'(0));
      check("R1 pending", 64'(pending), 64'(0));
      check("R1 ctrl", 64'(ctrl_rdata), 64'h0004_0100);
      check("R1 line", 64'(line_count), 64'(0));
      rst_n = 1'b1;
      mon_on = 1'b1;

      // R2 wrap and pulse
      wait_line(VTOTAL - 1);
      do @(negedge clk); while (!frame_start);
      check("R2 line at pulse", 64'(line_count), 64'(0));
      @(negedge clk);
      check("R2 pulse width", 64'(frame_start), 64'(0));
      wait_line(1);
      check("R2 advance", 64'(line_count), 64'(1));

      // R3/R4 default progressive window 12..15
      wait_line(11);  check("R3 line11", 64'(in_window), 64'(0));
      wait_line(12);  check("R3 line12", 64'(status_rdata[4]), 64'(1));
      wait_line(15);  check("R4 line15", 64'(in_window), 64'(1));

      // R8 just before close
      request(32'hA000_0000);
      @(negedge clk);
      check("R7 flag cleared", 64'(pending), 64'(0));
      wait_line(16);  check("R4 line16", 64'(in_window), 64'(0));

      // R8 just after close
      request(32'hB000_0000);
      wait_line(19);
      check("R6 pending", 64'(status_rdata[0]), 64'(1));
      check("R8 not yet", 64'(active_addr), 64'hA000_0000);
      wait_line(13);

      // R9 lock holds off
      wait_line(3);
      upd_lock = 1'b1;
      wait_line(5);
      stage(32'hC000_0000);
      wait_line(14);
      check("R9 locked in window", 64'(active_addr), 64'hB000_0000);
      check("R9 still pending", 64'(pending), 64'(1));
      stage(32'hD000_0000);
      wait_line(17);
      upd_lock = 1'b0;
      begin
         exp_t e;
         e.addr = 32'hD000_0000;
         e.frame = frame_id + 1;
         exp_q.push_back(e);
      end
      wait_line(13);
      check("R9 latest value", 64'(active_addr), 64'hD000_0000);

      // R5 progressive early bit with lead 6: window 12 only
      wait_line(2);
      write_ctrl(32'h0006_0001);
      check("R5 ctrl readback", 64'(ctrl_rdata), 64'h0006_0001);
      wait_line(12);  check("R5 prog line12", 64'(in_window), 64'(1));
      wait_line(13);  check("R5 prog line13", 64'(in_window), 64'(0));

      // R5 interlaced uses bit 8 (0 here), bit 0 ignored: window 12..13
      wait_line(2);
      interlace_mode = 1'b1;
      write_ctrl(32'h0006_0001);
      wait_line(13);  check("R5 intl line13", 64'(in_window), 64'(1));
      wait_line(14);  check("R5 intl line14", 64'(in_window), 64'(0));

      // R5 interlaced default: window 12..14; late request slips a frame
      wait_line(2);
      write_ctrl(32'h0004_0100);
      wait_line(14);  check("R5 intl early line14", 64'(in_window), 64'(1));
      wait_line(15);  check("R5 intl early line15", 64'(in_window), 64'(0));
      request(32'hE000_0000);
      wait_line(13);

      // R4 oversized lead empties the window
      interlace_mode = 1'b0;
      wait_line(2);
      write_ctrl(32'h000F_0000);
      wait_line(12);  check("R4 empty line12", 64'(in_window), 64'(0));
      wait_line(3);

      check("R8 scoreboard drained", 64'(exp_q.size()), 64'(0));
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule